// File: doc/BRIEF.md
# Mode-banked register file

This block holds the sixteen architectural integer registers of a processor core. The stack-pointer and link registers (indices 13 and 14) have a private copy for each privileged mode. The physical store therefore has 26 entries: sixteen base entries plus one pair for each of five privileged modes. Every architectural index that arrives on a read or write port is translated to a physical entry using the five-bit mode field of the current status word. Only indices 13 and 14 are ever translated.

The core reads two operands and writes one result per cycle. An exception sequencer reaches any of the 26 physical entries by its raw index through a separate debug port. It uses this port to save and restore banked state on exception entry. A write to index 15, the program counter, raises a same-cycle pulse that the core uses to start a return from exception.

Top module: `mbrf_top`

## Requirements
- R1: After reset every one of the 26 physical entries reads as zero.
- R2: Architectural indices 0 to 12 and 15 map to physical entries 0 to 12 and 15 in every mode value.
- R3: Mode 0x10 (user) and mode 0x1F (system) both use physical entries 13 and 14 for indices 13 and 14, so a value written in one mode is read back in the other.
- R4: For indices 13 and 14 respectively, mode 0x13 uses physical entries 16 and 17, mode 0x17 uses 18 and 19, mode 0x12 uses 20 and 21, and mode 0x11 uses 22 and 23.
- R5: Any mode value not named in R3 or R4 maps indices 13 and 14 to physical entries 24 and 25.
- R6: `exc_ret_o` is high in exactly those cycles in which `wr_en` is high with `wr_idx` equal to 15.
- R7: Reads are combinational. When a write in the same cycle targets the same physical entry, the read returns the data being written.
- R8: When the debug write and the normal write target the same physical entry in one cycle, the entry takes the debug data, and same-cycle reads of that entry return the debug data.
- R9: A debug index of 26 or above writes nothing, and a debug read at such an index returns zero.
- R10: The two operand read ports and the debug read port work independently, each returning its own entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current mode field from the status word |
| rd_a_idx | input | 4 | Architectural index, operand port A |
| rd_a_data | output | 32 | Operand port A data |
| rd_b_idx | input | 4 | Architectural index, operand port B |
| rd_b_data | output | 32 | Operand port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Architectural index for the normal write |
| wr_data | input | 32 | Normal write data |
| dbg_wr_en | input | 1 | Debug write enable |
| dbg_idx | input | 5 | Physical index for debug read and write |
| dbg_wr_data | input | 32 | Debug write data |
| dbg_rd_data | output | 32 | Debug read data |
| exc_ret_o | output | 1 | Pulse: the program counter is written this cycle |

## Verification
The properties assume that inputs are stable for a whole clock cycle and change only between rising edges. The persistence properties also assume a cycle that is free of writes before a value is read back, and their antecedents require that quiet cycle explicitly. The bench drives every input just after the falling edge. It spends directed phases on each mode value and on each shared or banked index, and it includes quiet cycles so that stored values, not only bypassed ones, are observed. A random phase then mixes mode values, including undefined codes, with colliding writes and debug indices beyond the physical range.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

   localparam int unsigned MODE_BITS = 5;

   // bank numbers; the physical pair of bank k starts at ARCH_REGS + 2*k
   typedef enum logic [2:0] {
      BK_SVC  = 3'd0,
      BK_ABT  = 3'd1,
      BK_IRQ  = 3'd2,
      BK_FIQ  = 3'd3,
      BK_UND  = 3'd4,
      BK_BASE = 3'd7
   } bank_e;

   localparam logic [MODE_BITS-1:0] MD_USR = 5'h10;
   localparam logic [MODE_BITS-1:0] MD_FIQ = 5'h11;
   localparam logic [MODE_BITS-1:0] MD_IRQ = 5'h12;
   localparam logic [MODE_BITS-1:0] MD_SVC = 5'h13;
   localparam logic [MODE_BITS-1:0] MD_ABT = 5'h17;
   localparam logic [MODE_BITS-1:0] MD_SYS = 5'h1F;

   function automatic bank_e bank_of_mode(input logic [MODE_BITS-1:0] m);
      bank_e b;
      case (m)
         MD_USR, MD_SYS: b = BK_BASE;
         MD_SVC:         b = BK_SVC;
         MD_ABT:         b = BK_ABT;
         MD_IRQ:         b = BK_IRQ;
         MD_FIQ:         b = BK_FIQ;
         default:        b = BK_UND;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/mbrf_remap.sv
module mbrf_remap
   import mbrf_pkg::*;
#(
   parameter int ARCH_REGS = 16,
   parameter int BANK_LO   = 13,
   parameter int BANK_SPAN = 2,
   parameter int IW        = 4,
   parameter int PW        = 5
) (
   input  logic [MODE_BITS-1:0] mode_i,
   input  logic [IW-1:0]        arch_i,
   output logic [PW-1:0]        phys_o
);

   bank_e       bank;
   logic        in_win;
   int unsigned off;

   always_comb begin
      bank   = bank_of_mode(mode_i);
      in_win = (int'(arch_i) >= BANK_LO) && (int'(arch_i) < BANK_LO + BANK_SPAN);
      off    = ARCH_REGS + int'(bank) * BANK_SPAN + (int'(arch_i) - BANK_LO);
      if (in_win && (bank != BK_BASE))
         phys_o = PW'(off);
      else
         phys_o = PW'(arch_i);
   end

endmodule

// File: rtl/mbrf_store.sv
module mbrf_store #(
   parameter int DATA_W = 32,
   parameter int PHYS   = 26,
   parameter int PW     = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          nw_en,
   input  logic [PW-1:0]                 nw_idx,
   input  logic [DATA_W-1:0]             nw_data,
   input  logic                          dw_en,
   input  logic [PW-1:0]                 dw_idx,
   input  logic [DATA_W-1:0]             dw_data,
   output logic [PHYS-1:0][DATA_W-1:0]   ent_o
);

   for (genvar g = 0; g < PHYS; g++) begin : g_ent
      logic              dhit;
      logic              nhit;
      logic [DATA_W-1:0] q;

      assign dhit = dw_en && (dw_idx == PW'(g));
      assign nhit = nw_en && (nw_idx == PW'(g));

      // debug write has priority over the normal write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (dhit)
            q <= dw_data;
         else if (nhit)
            q <= nw_data;
      end

      assign ent_o[g] = q;
   end

endmodule

// File: rtl/mbrf_rdport.sv
module mbrf_rdport #(
   parameter int DATA_W = 32,
   parameter int PHYS   = 26,
   parameter int PW     = 5
) (
   input  logic [PW-1:0]                 idx_i,
   input  logic [PHYS-1:0][DATA_W-1:0]   ent_i,
   input  logic                          nw_en,
   input  logic [PW-1:0]                 nw_idx,
   input  logic [DATA_W-1:0]             nw_data,
   input  logic                          dw_en,
   input  logic [PW-1:0]                 dw_idx,
   input  logic [DATA_W-1:0]             dw_data,
   output logic [DATA_W-1:0]             data_o
);

   always_comb begin
      if (int'(idx_i) >= PHYS)
         data_o = '0;
      else if (dw_en && (dw_idx == idx_i))
         data_o = dw_data;
      else if (nw_en && (nw_idx == idx_i))
         data_o = nw_data;
      else
         data_o = ent_i[idx_i];
   end

endmodule

// File: rtl/mbrf_top.sv
module mbrf_top
   import mbrf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ARCH_REGS = 16,
   parameter int BANK_LO   = 13,
   parameter int BANK_SPAN = 2,
   parameter int IW        = $clog2(ARCH_REGS),
   parameter int PW        = $clog2(ARCH_REGS + BANK_SPAN * 5)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [4:0]            mode_i,
   input  logic [IW-1:0]         rd_a_idx,
   output logic [DATA_W-1:0]     rd_a_data,
   input  logic [IW-1:0]         rd_b_idx,
   output logic [DATA_W-1:0]     rd_b_data,
   input  logic                  wr_en,
   input  logic [IW-1:0]         wr_idx,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  dbg_wr_en,
   input  logic [PW-1:0]         dbg_idx,
   input  logic [DATA_W-1:0]     dbg_wr_data,
   output logic [DATA_W-1:0]     dbg_rd_data,
   output logic                  exc_ret_o
);

   localparam int N_BANKS = 5;
   localparam int PHYS    = ARCH_REGS + BANK_SPAN * N_BANKS;
   localparam int PC_IDX  = ARCH_REGS - 1;
   localparam int N_MAP   = 3;   // read A, read B, write
   localparam int N_RD    = 3;   // read A, read B, debug

   // elaboration-time parameter checks
   if (IW != $clog2(ARCH_REGS)) begin : g_bad_iw
      $error("IW must equal clog2(ARCH_REGS)");
   end
   if (PW != $clog2(PHYS)) begin : g_bad_pw
      $error("PW must equal clog2 of the physical entry count");
   end
   if (BANK_LO + BANK_SPAN > PC_IDX) begin : g_bad_win
      $error("banked window must lie below the program counter index");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic [N_MAP-1:0][IW-1:0]   map_arch;
   logic [N_MAP-1:0][PW-1:0]   map_phys;
   logic [N_RD-1:0][PW-1:0]    rp_idx;
   logic [N_RD-1:0][DATA_W-1:0] rp_data;
   logic [PHYS-1:0][DATA_W-1:0] ent;

   assign map_arch[0] = rd_a_idx;
   assign map_arch[1] = rd_b_idx;
   assign map_arch[2] = wr_idx;

   for (genvar g = 0; g < N_MAP; g++) begin : g_map
      mbrf_remap #(
         .ARCH_REGS (ARCH_REGS),
         .BANK_LO   (BANK_LO),
         .BANK_SPAN (BANK_SPAN),
         .IW        (IW),
         .PW        (PW)
      ) u_map (
         .mode_i (mode_i),
         .arch_i (map_arch[g]),
         .phys_o (map_phys[g])
      );
   end

   mbrf_store #(
      .DATA_W (DATA_W),
      .PHYS   (PHYS),
      .PW     (PW)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .nw_en   (wr_en),
      .nw_idx  (map_phys[2]),
      .nw_data (wr_data),
      .dw_en   (dbg_wr_en),
      .dw_idx  (dbg_idx),
      .dw_data (dbg_wr_data),
      .ent_o   (ent)
   );

   assign rp_idx[0] = map_phys[0];
   assign rp_idx[1] = map_phys[1];
   assign rp_idx[2] = dbg_idx;

   for (genvar g = 0; g < N_RD; g++) begin : g_rd
      mbrf_rdport #(
         .DATA_W (DATA_W),
         .PHYS   (PHYS),
         .PW     (PW)
      ) u_rd (
         .idx_i   (rp_idx[g]),
         .ent_i   (ent),
         .nw_en   (wr_en),
         .nw_idx  (map_phys[2]),
         .nw_data (wr_data),
         .dw_en   (dbg_wr_en),
         .dw_idx  (dbg_idx),
         .dw_data (dbg_wr_data),
         .data_o  (rp_data[g])
      );
   end

   assign rd_a_data   = rp_data[0];
   assign rd_b_data   = rp_data[1];
   assign dbg_rd_data = rp_data[2];
   assign exc_ret_o   = wr_en && (wr_idx == IW'(PC_IDX));

endmodule

// File: rtl/mbrf_chk.sv
module mbrf_chk #(
   parameter int DATA_W    = 32,
   parameter int ARCH_REGS = 16,
   parameter int BANK_LO   = 13,
   parameter int BANK_SPAN = 2,
   parameter int IW        = 4,
   parameter int PW        = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        mode_i,
   input logic [IW-1:0]     rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [IW-1:0]     rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [IW-1:0]     wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              dbg_wr_en,
   input logic [PW-1:0]     dbg_idx,
   input logic [DATA_W-1:0] dbg_wr_data,
   input logic [DATA_W-1:0] dbg_rd_data,
   input logic              exc_ret_o
);

   localparam int PHYS = ARCH_REGS + BANK_SPAN * 5;

   logic usr_like;
   assign usr_like = (mode_i == 5'h10) || (mode_i == 5'h1F);

   // R2
   low_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en && !dbg_wr_en && (int'(wr_idx) < BANK_LO))
       && (rd_a_idx == $past(wr_idx)) && !wr_en && !dbg_wr_en)
      |-> (rd_a_data == $past(wr_data)));

   // R3
   shared_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en && !dbg_wr_en && (wr_idx == IW'(BANK_LO)) && usr_like)
       && usr_like && !wr_en && !dbg_wr_en && (rd_a_idx == IW'(BANK_LO)))
      |-> (rd_a_data == $past(wr_data)));

   // R6
   pc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == IW'(ARCH_REGS - 1))) |-> exc_ret_o);

   // R6
   no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !exc_ret_o);

   // R7
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dbg_wr_en && (rd_b_idx == wr_idx) && (int'(wr_idx) < BANK_LO))
      |-> (rd_b_data == wr_data));

   // R8
   dbg_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dbg_wr_en && (int'(dbg_idx) < PHYS))
       && (dbg_idx == $past(dbg_idx)) && !dbg_wr_en && !wr_en)
      |-> (dbg_rd_data == $past(dbg_wr_data)));

   // R9
   dbg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dbg_idx) >= PHYS) |-> (dbg_rd_data == '0));

endmodule

bind mbrf_top mbrf_chk #(
   .DATA_W    (DATA_W),
   .ARCH_REGS (ARCH_REGS),
   .BANK_LO   (BANK_LO),
   .BANK_SPAN (BANK_SPAN),
   .IW        (IW),
   .PW        (PW)
) u_chk (.*);

// File: tb/sim_mbrf_top.sv
module sim_mbrf_top;

   localparam int CLK_PERIOD = 10;
   localparam int NPHYS      = 26;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mode_i = 5'h10;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, dbg_rd_data;
   logic        wr_en = 1'b0, dbg_wr_en = 1'b0;
   logic [31:0] wr_data = '0, dbg_wr_data = '0;
   logic [4:0]  dbg_idx = '0;
   logic        exc_ret_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] mdl [NPHYS];

   always #(CLK_PERIOD/2) clk = ~clk;

   mbrf_top u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .dbg_wr_en(dbg_wr_en), .dbg_idx(dbg_idx), .dbg_wr_data(dbg_wr_data),
      .dbg_rd_data(dbg_rd_data), .exc_ret_o(exc_ret_o)
   );

   // behavioural mapping from the requirements (R2..R5)
   function automatic int ph(input int idx, input logic [4:0] m);
      int base;
      case (m)
         5'h13:        base = 16;
         5'h17:        base = 18;
         5'h12:        base = 20;
         5'h11:        base = 22;
         5'h10, 5'h1F: base = -1;
         default:      base = 24;
      endcase
      if ((idx == 13 || idx == 14) && base >= 0) return base + idx - 13;
      return idx;
   endfunction

   // expected read value of a physical entry this cycle (R7, R8, R9)
   function automatic logic [31:0] expv(input int p);
      if (p >= NPHYS) return 32'h0;
      if (dbg_wr_en && int'(dbg_idx) == p) return dbg_wr_data;
      if (wr_en && ph(int'(wr_idx), mode_i) == p) return wr_data;
      return mdl[p];
   endfunction

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
      end
   endtask

   task automatic cyc(input string tag);
      #1;
      if (rst_n) begin
         cmp(tag, "rd_a", rd_a_data, expv(ph(int'(rd_a_idx), mode_i)));
         cmp(tag, "rd_b", rd_b_data, expv(ph(int'(rd_b_idx), mode_i)));
         cmp(tag, "dbg", dbg_rd_data, expv(int'(dbg_idx)));
         cmp(tag, "exc_ret", {31'h0, exc_ret_o}, {31'h0, (wr_en && wr_idx == 4'd15)});
      end
      @(posedge clk);
      if (rst_n) begin
         if (wr_en) mdl[ph(int'(wr_idx), mode_i)] = wr_data;
         if (dbg_wr_en && int'(dbg_idx) < NPHYS) mdl[int'(dbg_idx)] = dbg_wr_data;
      end
      @(negedge clk);
   endtask

   task automatic quiet();
      wr_en = 1'b0; dbg_wr_en = 1'b0;
   endtask

   task automatic wr(input logic [4:0] m, input int idx, input logic [31:0] d, input string tag);
      mode_i = m; wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d; dbg_wr_en = 1'b0;
      rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
      cyc(tag);
      quiet();
   endtask

   task automatic rd(input logic [4:0] m, input int a, input int b, input int d, input string tag);
      quiet(); mode_i = m; rd_a_idx = 4'(a); rd_b_idx = 4'(b); dbg_idx = 5'(d);
      cyc(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog R1..all: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [4:0] modes [8];
      modes = '{5'h10, 5'h13, 5'h17, 5'h12, 5'h11, 5'h1F, 5'h00, 5'h1B};
      for (int i = 0; i < NPHYS; i++) mdl[i] = 32'h0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every physical entry zero after reset
      for (int p = 0; p < NPHYS; p++) rd(5'h10, p % 16, (p + 3) % 16, p, "R1");

      // R2: unbanked indices in every mode
      for (int mi = 0; mi < 8; mi++) begin
         for (int k = 0; k < 16; k++) begin
            if (k == 13 || k == 14) continue;
            wr(modes[mi], k, {8'hA0 + 8'(mi), 16'h0, 8'(k)}, "R2");
         end
         for (int k = 0; k < 16; k++) rd(modes[(mi + 3) % 8], k, 15 - k, k, "R2");
      end

      // R3: user and system share entries 13/14
      wr(5'h10, 13, 32'h1313_0010, "R3");
      wr(5'h1F, 14, 32'h1414_001F, "R3");
      rd(5'h1F, 13, 14, 13, "R3");
      rd(5'h10, 14, 13, 14, "R3");

      // R4: privileged banks land in 16..23
      wr(5'h13, 13, 32'h5D_0013, "R4"); wr(5'h13, 14, 32'h5E_0013, "R4");
      wr(5'h17, 13, 32'hAB_0017, "R4"); wr(5'h17, 14, 32'hAC_0017, "R4");
      wr(5'h12, 13, 32'h1A_0012, "R4"); wr(5'h12, 14, 32'h1B_0012, "R4");
      wr(5'h11, 13, 32'hF1_0011, "R4"); wr(5'h11, 14, 32'hF2_0011, "R4");
      for (int p = 13; p < 24; p++) rd(5'h10, 13, 14, p, "R4");
      rd(5'h11, 13, 14, 22, "R4");
      rd(5'h17, 14, 13, 19, "R4");

      // R5: unlisted modes use 24/25
      wr(5'h00, 13, 32'hDEAD_0000, "R5");
      wr(5'h1B, 14, 32'hDEAD_001B, "R5");
      rd(5'h16, 13, 14, 24, "R5");
      rd(5'h05, 14, 13, 25, "R5");

      // R6: pulse only on writes to 15
      wr(5'h13, 15, 32'h0000_0018, "R6");
      wr(5'h13, 12, 32'h0000_1212, "R6");
      rd(5'h13, 15, 15, 15, "R6");

      // R7: same-cycle bypass on banked and unbanked entries
      mode_i = 5'h12; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hB7B7_0001;
      rd_a_idx = 4'd14; rd_b_idx = 4'd3; dbg_idx = 5'd21; cyc("R7");
      wr_idx = 4'd3; wr_data = 32'hB7B7_0002; rd_b_idx = 4'd3; dbg_idx = 5'd3; cyc("R7");
      rd(5'h12, 14, 3, 21, "R7");

      // R8: debug write beats a normal write to the same entry
      mode_i = 5'h13; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h1111_1111;
      dbg_wr_en = 1'b1; dbg_idx = 5'd16; dbg_wr_data = 32'h2222_2222;
      rd_a_idx = 4'd13; rd_b_idx = 4'd13; cyc("R8");
      rd(5'h13, 13, 13, 16, "R8");

      // R9: out-of-range debug index
      for (int p = 26; p < 32; p++) begin
         quiet(); dbg_wr_en = 1'b1; dbg_idx = 5'(p); dbg_wr_data = 32'hBAD0_0000 + 32'(p);
         rd_a_idx = 4'(p - 26); rd_b_idx = 4'd13; cyc("R9");
      end
      for (int p = 0; p < NPHYS; p++) rd(5'h10, 0, 1, p, "R9");

      // R10: random mix on all three ports
      for (int n = 0; n < 4000; n++) begin
         mode_i      = ($urandom_range(0, 3) == 0) ? 5'($urandom) : modes[$urandom_range(0, 7)];
         rd_a_idx    = 4'($urandom);
         rd_b_idx    = 4'($urandom);
         wr_en       = ($urandom_range(0, 2) != 0);
         wr_idx      = ($urandom_range(0, 1) == 0) ? 4'($urandom_range(13, 15)) : 4'($urandom);
         wr_data     = $urandom;
         dbg_wr_en   = ($urandom_range(0, 3) == 0);
         dbg_idx     = 5'($urandom);
         dbg_wr_data = $urandom;
         cyc("R10");
      end
      quiet();
      for (int p = 0; p < NPHYS; p++) rd(5'h10, 13, 14, p, "R10");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule